// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block produces two pulse-width-modulated outputs from one peripheral clock. Each channel has its own divider, period/duty counter and output stage. A single-cycle register port holds the channel setup. One shared control word gives each channel a divider code, a run enable, a clock gate and an output polarity. Each channel also has its own period/duty word.

The divider does not use powers of two. It picks one of eleven fixed ratios, from divide-by-one up to divide-by-72000, and some codes are reserved. At every divided tick the channel counter advances from zero up to the programmed period value and then wraps. The output is in its active level while the count is below the duty value.

A new period/duty word waits in a shadow copy and takes effect at the next wrap, so a running waveform never shows a broken period. A per-channel busy flag in the control word shows that a shadow value is still waiting. Software polls that flag before it writes the same channel again.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset both outputs are high (inverted polarity with zero duty), the control word reads 0 and both period/duty words read 0.
- R2: In the control word, channel n uses bits starting at 15·n: [3:0] divider code, bit 4 enable, bit 5 polarity (1 = normal), bit 6 clock gate. Bits 28+n read as the channel-n busy flag. Every other bit reads 0, whatever was written.
- R3: Byte address 4+4·n selects channel n's period/duty word: bits [31:16] hold period minus one and bits [15:0] hold duty. A read returns the last value written. Address 0 selects the control word. Any other address, including one with nonzero bits [1:0], reads 0 and ignores writes. Read data appears the cycle after the read strobe.
- R4: Divider codes 0–4 give ratios 120, 180, 240, 360, 480. Codes 8–12 give 12000, 24000, 36000, 48000, 72000. Code 15 gives 1. One output period lasts ratio·(period+1) clock cycles.
- R5: With normal polarity the output is high for ratio·min(duty, period+1) cycles of each period. Duty 0 gives a constant low. A duty above the period gives a constant high.
- R6: With the polarity bit at 0 the output is the complement of the normal-polarity waveform.
- R7: The counter advances only while both enable and clock gate are 1. If either is 0, the counter and the output hold.
- R8: Reserved divider codes (5–7, 13, 14) stop the counter even when enable and gate are set.
- R9: A period/duty write sets that channel's busy flag. The flag stays set, and the old values stay in use, until the counter next wraps. The new values apply from that wrap, which also clears the flag.
- R10: A write to one channel's period/duty word, or to its control fields, leaves the other channel's waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_re | input | 1 | Register read strobe, one cycle |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| pwm_out | output | 2 | Registered channel outputs, bit n is channel n |

## Verification
The assertions assume that a write never targets a channel whose busy flag is set. They also assume that the divider code stays unchanged while its channel runs, except at deliberate reconfiguration points. The stimulus waits for the busy flag to clear by polling the control word before every period/duty write. It changes divider codes only between measurement windows and measures duty only after a full settling period. Random periods stay in 1–12 ticks and random duties in 0 to period+2, so both the partial-duty case and the saturated case occur.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int NCH        = 2;
  localparam int REG_W      = 32;
  localparam int HALF_W     = 16;
  localparam int CODE_W     = 4;
  localparam int FLD_W      = 7;
  localparam int FLD_STRIDE = 15;
  localparam int BUSY_LSB   = 28;
  localparam int RATIO_W    = 17;

  typedef struct packed {
    logic              gate;
    logic              pol;
    logic              en;
    logic [CODE_W-1:0] code;
  } chan_cfg_t;

  // Divider ratio for a code; 0 marks a reserved code.
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd0:    r = RATIO_W'(120);
      4'd1:    r = RATIO_W'(180);
      4'd2:    r = RATIO_W'(240);
      4'd3:    r = RATIO_W'(360);
      4'd4:    r = RATIO_W'(480);
      4'd8:    r = RATIO_W'(12000);
      4'd9:    r = RATIO_W'(24000);
      4'd10:   r = RATIO_W'(36000);
      4'd11:   r = RATIO_W'(48000);
      4'd12:   r = RATIO_W'(72000);
      4'd15:   r = RATIO_W'(1);
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
  import pwm2_pkg::*;
#(
  parameter int DIV_W = RATIO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              run_req,
  output logic              run,
  output logic              tick
);
  logic [DIV_W-1:0]  ratio;
  logic [DIV_W-1:0]  pcnt;
  logic [CODE_W-1:0] code_q;
  logic              code_chg;

  assign ratio    = DIV_W'(ratio_of(code));
  assign run      = run_req && (ratio != '0);
  assign code_chg = (code != code_q);
  assign tick     = run && !code_chg && (pcnt == ratio - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt   <= '0;
      code_q <= '0;
    end else begin
      code_q <= code;
      if (!run || code_chg || tick) pcnt <= '0;
      else                          pcnt <= pcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               pol,
  input  logic               wr,
  input  logic [CNT_W-1:0]   wr_prd,
  input  logic [CNT_W-1:0]   wr_dty,
  output logic               busy,
  output logic               out,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   prd_act,
  output logic [2*CNT_W-1:0] shadow
);
  logic [CNT_W-1:0] sh_prd, sh_dty, dty_act;
  logic             wrap, raw;

  assign wrap   = tick && (cnt == prd_act);
  assign raw    = (cnt < dty_act);
  assign shadow = {sh_prd, sh_dty};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      prd_act <= '0;
      dty_act <= '0;
      sh_prd  <= '0;
      sh_dty  <= '0;
      busy    <= 1'b0;
      out     <= 1'b1;
    end else begin
      if (tick) cnt <= wrap ? '0 : cnt + CNT_W'(1);
      if (wrap && busy) begin
        prd_act <= sh_prd;
        dty_act <= sh_dty;
      end
      if (wr) begin
        sh_prd <= wr_prd;
        sh_dty <= wr_dty;
        busy   <= 1'b1;
      end else if (wrap) begin
        busy   <= 1'b0;
      end
      out <= pol ? raw : ~raw;
    end
  end
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]        word;
  logic                     aligned, ctrl_wr;
  logic [NCH*FLD_W-1:0]     cfg_flat;
  logic [NCH*CODE_W-1:0]    code_flat;
  logic [NCH-1:0]           pol_vec, run_vec, busy_vec;
  logic [NCH*HALF_W-1:0]    cnt_flat, prd_flat;
  logic [NCH*REG_W-1:0]     shadow_flat;
  logic [REG_W-1:0]         ctrl_img, rd_mux;

  assign word    = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign ctrl_wr = reg_we && aligned && (word == '0);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    chan_cfg_t cfg_q;
    logic      tick, wr;

    always_ff @(posedge clk) begin
      if (rst)          cfg_q <= '0;
      else if (ctrl_wr) cfg_q <= chan_cfg_t'(reg_wdata[n*FLD_STRIDE +: FLD_W]);
    end

    assign wr = reg_we && aligned && (word == WORD_W'(n + 1));
    assign cfg_flat[n*FLD_W +: FLD_W]    = cfg_q;
    assign code_flat[n*CODE_W +: CODE_W] = cfg_q.code;
    assign pol_vec[n]                    = cfg_q.pol;

    pwm2_prescaler u_div (
      .clk     (clk),
      .rst     (rst),
      .code    (cfg_q.code),
      .run_req (cfg_q.en && cfg_q.gate),
      .run     (run_vec[n]),
      .tick    (tick)
    );

    pwm2_channel #(.CNT_W(HALF_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .pol     (cfg_q.pol),
      .wr      (wr),
      .wr_prd  (reg_wdata[REG_W-1:HALF_W]),
      .wr_dty  (reg_wdata[HALF_W-1:0]),
      .busy    (busy_vec[n]),
      .out     (pwm_out[n]),
      .cnt     (cnt_flat[n*HALF_W +: HALF_W]),
      .prd_act (prd_flat[n*HALF_W +: HALF_W]),
      .shadow  (shadow_flat[n*REG_W +: REG_W])
    );
  end

  always_comb begin
    ctrl_img = '0;
    for (int n = 0; n < NCH; n++) begin
      ctrl_img[n*FLD_STRIDE +: FLD_W] = cfg_flat[n*FLD_W +: FLD_W];
      ctrl_img[BUSY_LSB + n]          = busy_vec[n];
    end
    rd_mux = '0;
    if (aligned) begin
      if (word == '0) rd_mux = ctrl_img;
      for (int n = 0; n < NCH; n++)
        if (word == WORD_W'(n + 1)) rd_mux = shadow_flat[n*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
module pwm2_ctrl_chk
  import pwm2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [NCH-1:0]        pwm_out,
  input logic [NCH-1:0]        busy_vec,
  input logic [NCH-1:0]        run_vec,
  input logic [NCH-1:0]        pol_vec,
  input logic [NCH*CODE_W-1:0] code_flat,
  input logic [NCH*HALF_W-1:0] cnt_flat,
  input logic [NCH*HALF_W-1:0] prd_flat
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pwm_out == '1 && busy_vec == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R9
    busy_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_vec[n]) |-> $past(reg_we && reg_addr == ADDR_W'(4 * (n + 1))));

    // R7
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_vec[n] && $past(!run_vec[n]) && $stable(pol_vec[n])) |=> $stable(pwm_out[n]));

    // R8
    reserved_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (ratio_of(code_flat[n*CODE_W +: CODE_W]) == '0) |=> $stable(cnt_flat[n*HALF_W +: HALF_W]));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[n*HALF_W +: HALF_W] <= prd_flat[n*HALF_W +: HALF_W]);
  end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.ADDR_W(ADDR_W)) u_pwm2_ctrl_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .pwm_out   (pwm_out),
  .busy_vec  (busy_vec),
  .run_vec   (run_vec),
  .pol_vec   (pol_vec),
  .code_flat (code_flat),
  .cnt_flat  (cnt_flat),
  .prd_flat  (prd_flat)
);

// File: tb/pwm2_ctrl_bench.sv
`timescale 1ns/1ps
module pwm2_ctrl_bench;
  localparam real CLK_PER = 5.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_code [2];
  logic       m_en [2], m_pol [2], m_gate [2];

  always #(CLK_PER / 2) clk = ~clk;

  pwm2_ctrl u_pwm2_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word();
    logic [31:0] w = '0;
    for (int n = 0; n < 2; n++)
      w[n*15 +: 7] = {m_gate[n], m_pol[n], m_en[n], m_code[n]};
    return w;
  endfunction

  task automatic push_ctrl();
    wr(4'h0, ctrl_word());
  endtask

  task automatic wait_idle(input int ch);
    logic [31:0] d;
    bit idle = 1'b0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      rd(4'h0, d);
      idle = !d[28 + ch];
    end
    chk("R9 busy clears", idle, 1);
  endtask

  task automatic set_chan(input int ch, input int p, input int dty);
    wr(4'(4 + 4 * ch), {16'(p), 16'(dty)});
    wait_idle(ch);
  endtask

  task automatic measure(input int ch, input int n, output int highs, output int rises);
    logic prev, cur;
    highs = 0; rises = 0;
    @(negedge clk); prev = pwm_out[ch];
    for (int i = 0; i < n; i++) begin
      if (prev) highs++;
      @(negedge clk); cur = pwm_out[ch];
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  function automatic int exp_high(int p, int dty, bit pol, int ratio, int k);
    int act = (dty < p + 1) ? dty : p + 1;
    return k * ratio * (pol ? act : (p + 1 - act));
  endfunction

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h, r, seed;
    int p [2], dt [2];
    seed = $urandom(32'd1234);
    for (int n = 0; n < 2; n++) begin
      m_code[n] = 4'd15; m_en[n] = 1'b1; m_pol[n] = 1'b1; m_gate[n] = 1'b1;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", pwm_out, 2'b11);
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 ch0 word", d, 0);
    rd(4'h8, d); chk("R1 ch1 word", d, 0);

    // R2 field layout and reserved bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 all ones readback", d, 32'h003F_807F);
    m_code[0] = 4'd2; m_en[0] = 1'b0; m_pol[0] = 1'b1; m_gate[0] = 1'b0;
    m_code[1] = 4'd9; m_en[1] = 1'b1; m_pol[1] = 1'b0; m_gate[1] = 1'b1;
    push_ctrl();
    rd(4'h0, d); chk("R2 mixed fields", d, ctrl_word());
    for (int n = 0; n < 2; n++) begin
      m_code[n] = 4'd15; m_en[n] = 1'b1; m_pol[n] = 1'b1; m_gate[n] = 1'b1;
    end
    push_ctrl();

    // R3 period/duty word and decode
    wr(4'h8, 32'h0007_0003);
    rd(4'h8, d); chk("R3 ch1 readback", d, 32'h0007_0003);
    rd(4'hC, d); chk("R3 unmapped read", d, 0);
    wait_idle(1);
    wr(4'h5, 32'h0009_0009);
    rd(4'h4, d); chk("R3 unaligned write ignored", d, 0);
    rd(4'h0, d); chk("R3 unaligned sets no busy", d[29:28], 0);

    // R5 R6 R10 random configurations at divide-by-one
    for (int it = 0; it < 16; it++) begin
      for (int n = 0; n < 2; n++) begin
        p[n] = $urandom_range(1, 12);
        dt[n] = $urandom_range(0, p[n] + 2);
        m_pol[n] = 1'($urandom_range(0, 1));
      end
      push_ctrl();
      set_chan(0, p[0], dt[0]);
      set_chan(1, p[1], dt[1]);
      for (int n = 0; n < 2; n++) begin
        measure(n, 2 * (p[n] + 1), h, r);
        chk(m_pol[n] ? "R5 R10 duty high count" : "R6 R10 inverted high count",
            h, exp_high(p[n], dt[n], m_pol[n], 1, 2));
        if (dt[n] > 0 && dt[n] <= p[n]) chk("R4 pulses per window", r, 2);
      end
    end

    // R4 divider ratios 120 and 180
    m_pol[0] = 1'b1; push_ctrl();
    set_chan(0, 3, 1);
    m_code[0] = 4'd0; push_ctrl();
    repeat (500) @(negedge clk);
    measure(0, 960, h, r);
    chk("R4 ratio 120 high", h, 240);
    chk("R4 ratio 120 pulses", r, 2);
    m_code[0] = 4'd15; push_ctrl();
    set_chan(0, 1, 1);
    m_code[0] = 4'd1; push_ctrl();
    repeat (400) @(negedge clk);
    measure(0, 720, h, r);
    chk("R4 ratio 180 high", h, 360);
    chk("R4 ratio 180 pulses", r, 2);

    // R7 R9 stop with pending write
    m_code[0] = 4'd15; push_ctrl();
    set_chan(0, 9, 5);
    m_gate[0] = 1'b0; push_ctrl();
    wr(4'h4, {16'd3, 16'd3});
    rd(4'h0, d); chk("R9 busy after write", d[28], 1);
    repeat (50) @(negedge clk);
    measure(0, 20, h, r);
    chk("R7 gate off holds", (h == 0 || h == 20) && r == 0, 1);
    rd(4'h0, d); chk("R9 busy held while stopped", d[28], 1);
    m_gate[0] = 1'b1; m_en[0] = 1'b0; push_ctrl();
    repeat (5) @(negedge clk);
    measure(0, 20, h, r);
    chk("R7 enable off holds", (h == 0 || h == 20) && r == 0, 1);
    m_en[0] = 1'b1; push_ctrl();
    wait_idle(0);
    measure(0, 8, h, r);
    chk("R9 new value after wrap", h, 6);

    // R8 reserved code
    m_code[0] = 4'd5; push_ctrl();
    wr(4'h4, {16'd5, 16'd2});
    repeat (40) @(negedge clk);
    rd(4'h0, d); chk("R8 busy held on reserved code", d[28], 1);
    measure(0, 30, h, r);
    chk("R8 reserved code holds", (h == 0 || h == 30) && r == 0, 1);
    m_code[0] = 4'd15; push_ctrl();
    wait_idle(0);
    measure(0, 12, h, r);
    chk("R8 resumes after valid code", h, 4);

    // R6 directed
    m_pol[0] = 1'b0; push_ctrl();
    set_chan(0, 4, 0);
    measure(0, 10, h, r);
    chk("R6 zero duty inverted high", h, 10);
    set_chan(0, 4, 2);
    measure(0, 10, h, r);
    chk("R6 inverted partial", h, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule